// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Operation Unit

This block carries out the operations that an 8-bit microprocessor encodes in the second byte of its bit-manipulation prefix group. It decodes that byte into one of eight rotate or shift kinds, or into a bit test, bit clear or bit set. It then computes the new byte, the new carry and the zero, sign and parity flags. The operand byte and the incoming carry come straight from the caller. Register-file reads, memory operand fetch and indexed addressing all stay outside the unit.

A single-cycle start strobe captures the opcode, the operand and the carry. On the next clock edge the unit registers the result, a write-back enable, the flags and a one-cycle done pulse. The 3-bit register field of the opcode is returned unchanged as a destination tag, so the pipeline knows where the result goes. When start is low, the outputs keep their last values and neither done nor write-back is raised.

Top module: `prefix_bit_unit`

## Requirements
- R1: While reset is asserted, and until the first start, every output is 0.
- R2: done_o is high in the cycle after each cycle that has start_i high, and low after every cycle with start_i low.
- R3: With op_i[7:6]=00, op_i[5:3]=000 rotates left with bit 7 going to both carry and bit 0. Code 001 rotates right with bit 0 going to both carry and bit 7.
- R4: Shift-class code 010 shifts left, with the incoming carry entering bit 0 and bit 7 becoming the carry. Code 011 shifts right, with the incoming carry entering bit 7 and bit 0 becoming the carry.
- R5: Shift-class code 100 shifts left with 0 into bit 0 and bit 7 to carry. Code 111 shifts right with 0 into bit 7 and bit 0 to carry. Code 101 shifts right with bit 7 kept and bit 0 to carry.
- R6: Shift-class code 110 shifts left with 1 into bit 0 and bit 7 to carry.
- R7: With op_i[7:6]=01 (test bit b=op_i[5:3]), result_o is operand AND (1<<b), wr_en_o stays 0, and carry_o equals the incoming carry.
- R8: With op_i[7:6]=10, result_o is operand with bit b cleared. With 11, result_o is operand with bit b set. Both raise wr_en_o and pass the incoming carry through.
- R9: With each done pulse, zero_o is 1 exactly when result_o is 0, sign_o equals result_o bit 7, and parity_o is 1 when result_o has an even number of ones.
- R10: With each done pulse, dest_o equals op_i[2:0] of the captured opcode, and every shift-class operation raises wr_en_o.
- R11: With start_i low, result_o, carry_o, the flags and dest_o hold their values, and wr_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture strobe for opcode, operand and carry |
| op_i | input | 8 | Second byte of the prefixed opcode |
| operand_i | input | 8 | Operand byte |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 8 | Computed byte (masked byte for bit test) |
| wr_en_o | output | 1 | Result should be written to the destination |
| carry_o | output | 1 | New carry flag |
| zero_o | output | 1 | Result is zero |
| sign_o | output | 1 | Result bit 7 |
| parity_o | output | 1 | Result has even parity |
| dest_o | output | 3 | Destination register tag from op_i[2:0] |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions assume that op_i, operand_i, carry_i and start_i have known values and are stable around each rising edge. They also assume that every one of the 256 opcode values is legal. The bench keeps within these assumptions by driving all inputs on the falling edge. It sweeps every opcode value against operand bytes at a stride of three, including 0x00 and 0xFF, under both carry values, and then runs idle stretches with start low.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    K_ROL_C  = 4'd0,
    K_ROR_C  = 4'd1,
    K_ROL_T  = 4'd2,
    K_ROR_T  = 4'd3,
    K_SHL_0  = 4'd4,
    K_SHR_S  = 4'd5,
    K_SHL_1  = 4'd6,
    K_SHR_0  = 4'd7,
    K_TEST   = 4'd8,
    K_CLEAR  = 4'd9,
    K_SETB   = 4'd10
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic [IDX_W-1:0]   idx;
    logic [2:0]         tag;
  } dec_t;

  function automatic logic even_parity(input logic [BYTE_W-1:0] v);
    return ~(^v);
  endfunction

  // returns {carry_out, result}
  function automatic logic [BYTE_W:0] rotshift(input kind_e k,
                                               input logic [BYTE_W-1:0] v,
                                               input logic cin);
    logic [BYTE_W-1:0] r;
    logic              c;
    r = v;
    c = cin;
    case (k)
      K_ROL_C: begin r = {v[BYTE_W-2:0], v[BYTE_W-1]}; c = v[BYTE_W-1]; end
      K_ROR_C: begin r = {v[0], v[BYTE_W-1:1]};        c = v[0];        end
      K_ROL_T: begin r = {v[BYTE_W-2:0], cin};         c = v[BYTE_W-1]; end
      K_ROR_T: begin r = {cin, v[BYTE_W-1:1]};         c = v[0];        end
      K_SHL_0: begin r = {v[BYTE_W-2:0], 1'b0};        c = v[BYTE_W-1]; end
      K_SHR_S: begin r = {v[BYTE_W-1], v[BYTE_W-1:1]}; c = v[0];        end
      K_SHL_1: begin r = {v[BYTE_W-2:0], 1'b1};        c = v[BYTE_W-1]; end
      K_SHR_0: begin r = {1'b0, v[BYTE_W-1:1]};        c = v[0];        end
      default: begin r = v;                            c = cin;         end
    endcase
    return {c, r};
  endfunction
endpackage

// File: rtl/pbu_decode.sv
module pbu_decode
  import pbu_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  output dec_t              dec_o
);
  logic [1:0] cls;
  assign cls = op_i[7:6];

  always_comb begin
    dec_o.idx = op_i[5:3];
    dec_o.tag = op_i[2:0];
    case (cls)
      2'b00:   dec_o.kind = kind_e'({1'b0, op_i[5:3]});
      2'b01:   dec_o.kind = K_TEST;
      2'b10:   dec_o.kind = K_CLEAR;
      default: dec_o.kind = K_SETB;
    endcase
  end
endmodule

// File: rtl/pbu_shift.sv
module pbu_shift
  import pbu_pkg::*;
(
  input  kind_e             kind_i,
  input  logic [BYTE_W-1:0] val_i,
  input  logic              cin_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              cout_o
);
  logic [BYTE_W:0] packed_out;
  assign packed_out = rotshift(kind_i, val_i, cin_i);
  assign res_o  = packed_out[BYTE_W-1:0];
  assign cout_o = packed_out[BYTE_W];
endmodule

// File: rtl/pbu_bitop.sv
module pbu_bitop
  import pbu_pkg::*;
(
  input  kind_e             kind_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] val_i,
  output logic [BYTE_W-1:0] res_o
);
  logic [BYTE_W-1:0] mask;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
    assign mask[i] = (idx_i == IDX_W'(i));
  end

  always_comb begin
    case (kind_i)
      K_TEST:  res_o = val_i & mask;
      K_CLEAR: res_o = val_i & ~mask;
      K_SETB:  res_o = val_i | mask;
      default: res_o = val_i;
    endcase
  end
endmodule

// File: rtl/prefix_bit_unit.sv
module prefix_bit_unit
  import pbu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] op_i,
  input  logic [7:0] operand_i,
  input  logic       carry_i,
  output logic [7:0] result_o,
  output logic       wr_en_o,
  output logic       carry_o,
  output logic       zero_o,
  output logic       sign_o,
  output logic       parity_o,
  output logic [2:0] dest_o,
  output logic       done_o
);
  dec_t              dec;
  logic [BYTE_W-1:0] sh_res, bit_res, nxt_res;
  logic              sh_cout, nxt_carry, nxt_wr, is_bitclass;

  pbu_decode u_dec (.op_i(op_i), .dec_o(dec));

  pbu_shift u_sh (
    .kind_i(dec.kind), .val_i(operand_i), .cin_i(carry_i),
    .res_o(sh_res), .cout_o(sh_cout)
  );

  pbu_bitop u_bit (
    .kind_i(dec.kind), .idx_i(dec.idx), .val_i(operand_i), .res_o(bit_res)
  );

  assign is_bitclass = (dec.kind == K_TEST) || (dec.kind == K_CLEAR) ||
                       (dec.kind == K_SETB);
  assign nxt_res   = is_bitclass ? bit_res : sh_res;
  assign nxt_carry = is_bitclass ? carry_i : sh_cout;
  assign nxt_wr    = (dec.kind != K_TEST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
      sign_o   <= 1'b0;
      parity_o <= 1'b0;
      dest_o   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o  <= start_i;
      wr_en_o <= start_i & nxt_wr;
      if (start_i) begin
        result_o <= nxt_res;
        carry_o  <= nxt_carry;
        zero_o   <= (nxt_res == '0);
        sign_o   <= nxt_res[BYTE_W-1];
        parity_o <= even_parity(nxt_res);
        dest_o   <= dec.tag;
      end
    end
  end

  // R2: a done pulse follows every start
  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  // R2: no done without start
  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  // R11: idle keeps result, no write-back
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(result_o) && $stable(carry_o) && !wr_en_o));
  // R7: bit test never writes back
  p_test_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i[7:6] == 2'b01) |=> !wr_en_o);
  // R8: bit clear/set keep carry
  p_carry_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i[7]) |=> (carry_o == $past(carry_i) && wr_en_o));
  // R10: destination tag comes from the register field
  p_dest_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> dest_o == $past(op_i[2:0]));
  // R9: zero and sign agree with the presented result
  p_flags_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (zero_o == (result_o == 8'd0)) && (sign_o == result_o[7]));
  // R4: through-carry left rotate feeds bit 0 from the old carry
  p_rl_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i[7:3] == 5'b00010) |=> result_o[0] == $past(carry_i));
endmodule

// File: tb/test_prefix_bit_unit.sv
`timescale 1ns/1ps
module test_prefix_bit_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic       carry_i = 1'b0;
  logic [7:0] result_o;
  logic       wr_en_o, carry_o, zero_o, sign_o, parity_o, done_o;
  logic [2:0] dest_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prefix_bit_unit i_prefix_bit_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .operand_i(operand_i), .carry_i(carry_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .carry_o(carry_o), .zero_o(zero_o), .sign_o(sign_o),
    .parity_o(parity_o), .dest_o(dest_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h op=%0h v=%0h c=%0b",
               req, act, exp, op_i, operand_i, carry_i);
    end
  endtask

  // independent arithmetic model
  task automatic model(input int op, input int v, input int c,
                       output int res, output int cout, output int wr,
                       output string req);
    int cls, sel, b;
    cls = op / 64;
    sel = (op / 8) % 8;
    b   = sel;
    wr  = 1;
    cout = c;
    res = v;
    if (cls == 0) begin
      case (sel)
        0: begin res = ((v * 2) % 256) + v / 128;   cout = v / 128; req = "R3"; end
        1: begin res = v / 2 + (v % 2) * 128;       cout = v % 2;   req = "R3"; end
        2: begin res = ((v * 2) % 256) + c;         cout = v / 128; req = "R4"; end
        3: begin res = v / 2 + c * 128;             cout = v % 2;   req = "R4"; end
        4: begin res = (v * 2) % 256;               cout = v / 128; req = "R5"; end
        5: begin res = v / 2 + (v / 128) * 128;     cout = v % 2;   req = "R5"; end
        6: begin res = ((v * 2) % 256) + 1;         cout = v / 128; req = "R6"; end
        default: begin res = v / 2;                 cout = v % 2;   req = "R5"; end
      endcase
    end else if (cls == 1) begin
      res = ((v / (1 << b)) % 2) * (1 << b);
      wr = 0; req = "R7";
    end else if (cls == 2) begin
      res = v - ((v / (1 << b)) % 2) * (1 << b); req = "R8";
    end else begin
      res = v + (1 - (v / (1 << b)) % 2) * (1 << b); req = "R8";
    end
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int er, ec, ew;
    string rq;
    int last_res, last_c;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", {result_o, wr_en_o, carry_o, zero_o, sign_o, parity_o, dest_o, done_o}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", {result_o, done_o, wr_en_o}, 0);

    for (int op = 0; op < 256; op++) begin
      for (int v = 0; v < 256; v += 3) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          op_i = 8'(op); operand_i = 8'(v); carry_i = c[0]; start_i = 1'b1;
          model(op, v, c, er, ec, ew, rq);
          @(posedge clk); #1;
          chk("R2", done_o, 1);
          chk(rq, result_o, er);
          chk(rq, carry_o, ec);
          chk(op < 64 ? "R10" : rq, wr_en_o, ew);
          chk("R9", zero_o, er == 0 ? 1 : 0);
          chk("R9", sign_o, er / 128);
          chk("R9", parity_o, (ones(er) % 2 == 0) ? 1 : 0);
          chk("R10", dest_o, op % 8);
        end
      end
    end

    // R11: idle stretch after a writing operation; inputs change but are ignored
    @(negedge clk);
    op_i = 8'hC7; operand_i = 8'h10; carry_i = 1'b1; start_i = 1'b1;
    @(posedge clk); #1;
    last_res = result_o; last_c = carry_o;
    chk("R8", result_o, 8'h11);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      start_i = 1'b0; op_i = 8'(k * 37); operand_i = 8'(k * 91 + 5); carry_i = k[0];
      @(posedge clk); #1;
      chk("R2", done_o, 0);
      chk("R11", wr_en_o, 0);
      chk("R11", result_o, last_res);
      chk("R11", carry_o, last_c);
      chk("R11", dest_o, 7);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule